// File: doc/BRIEF.md
# Manchester Line Encoder

This block turns a parallel payload word into a self-clocking serial line. A word is offered on a data input together with a one-cycle start strobe; the block then sends a frame made of one forced-zero guard bit followed by the payload, highest bit first. Each bit is split into two equal halves. The line level in each half is the exclusive-or of the data bit with a half-bit timing phase that is low in the first half and high in the second. Every bit therefore carries a transition at its middle. The timing phase itself never leaves the block, so the receiver has to recover timing from the line alone.

The guard bit always encodes as low-then-high. A receiver that gates on transitions can align on its mid-bit rising edge whatever the payload is, including payloads whose top bit is one. A busy flag covers the whole frame. Between frames the line rests low. The bit period is a parameter counted in system clocks.

Top module: `manch_tx`

## Requirements
- R1: After reset and whenever busy_o is low, line_o is 0 and busy_o stays 0 until a start is accepted.
- R2: A start_i pulse sampled while busy_o is low is accepted; busy_o is 1 in the cycle after that clock edge.
- R3: The first bit period after acceptance is the guard bit of value 0: line_o is 0 for the first half and 1 for the second half.
- R4: After the guard bit, the payload bits follow from data_i[WORD_W-1] down to data_i[0], using the value latched at acceptance.
- R5: A payload bit of 1 shows as line_o high in the first half and low in the second half, which is a falling edge at mid-bit.
- R6: A payload bit of 0 shows as line_o low in the first half and high in the second half, which is a rising edge at mid-bit.
- R7: Each half-bit lasts exactly BIT_CYCLES/2 clock cycles, and line_o changes only at half-bit boundaries.
- R8: busy_o stays high for exactly (WORD_W+1)*BIT_CYCLES cycles per frame, then drops with the line returning low.
- R9: A start_i pulse while busy_o is high is ignored: the frame in flight and its length are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled on the clock edge |
| data_i | input | WORD_W | Payload word, latched when a start is accepted |
| busy_o | output | 1 | High while a frame is being sent |
| line_o | output | 1 | Manchester-coded serial line, idle low |

## Verification
The hardest case to reach from the ports is a start strobe that lands in the middle of a frame. The data offered with it differs from the word in flight, and the design must neither reload nor stretch the frame. The bench sends a word, waits several half-bits, and pulses start with a conflicting word. The scoreboard still holds the original cycle-by-cycle line pattern, so any reload or timing slip shows up as a mismatch. Back-to-back frames are started on the first idle cycle. This exercises the hand-off between the end of a frame and the next acceptance.

// File: rtl/manch_pkg.sv
package manch_pkg;

  // Line level for one half of a bit: the data bit XOR the half-bit phase.
  function automatic logic line_level(input logic data_bit, input logic second_half);
    return data_bit ^ second_half;
  endfunction

  // Total bits per frame: one guard bit plus the payload.
  function automatic int frame_bits(input int word_w);
    return word_w + 1;
  endfunction

endpackage

// File: rtl/manch_div.sv
module manch_div #(
  parameter int HALF_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic half_tick,
  output logic second_half
);
  localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (clear) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (run) begin
      if (cnt_q == LAST) begin
        cnt_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign half_tick   = run && (cnt_q == LAST);
  assign second_half = phase_q;
endmodule

// File: rtl/manch_shift.sv
module manch_shift #(
  parameter int FRAME_BITS = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] load_frame,
  input  logic                  advance,
  output logic                  cur_bit,
  output logic                  last_bit
);
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] sh_q;
  logic [IW-1:0]         idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sh_q  <= load_frame;
      idx_q <= '0;
    end else if (advance) begin
      sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign cur_bit  = sh_q[FRAME_BITS-1];
  assign last_bit = (idx_q == LAST_IDX);
endmodule

// File: rtl/manch_tx.sv
module manch_tx
  import manch_pkg::*;
#(
  parameter int WORD_W     = 8,
  parameter int BIT_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              busy_o,
  output logic              line_o
);
  localparam int HALF_CYCLES = BIT_CYCLES / 2;
  localparam int FRAME_BITS  = frame_bits(WORD_W);

  logic busy_q;
  logic accept;
  logic half_tick;
  logic second_half;
  logic bit_tick;
  logic cur_bit;
  logic last_bit;
  logic frame_done;
  logic [FRAME_BITS-1:0] frame_word;

  assign accept     = start_i && !busy_q;
  assign frame_word = {1'b0, data_i};
  assign bit_tick   = half_tick && second_half;
  assign frame_done = bit_tick && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy_q <= 1'b0;
    else if (accept)     busy_q <= 1'b1;
    else if (frame_done) busy_q <= 1'b0;
  end

  manch_div #(.HALF_CYCLES(HALF_CYCLES)) u_div (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (accept),
    .run         (busy_q),
    .half_tick   (half_tick),
    .second_half (second_half)
  );

  manch_shift #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .load_frame (frame_word),
    .advance    (bit_tick),
    .cur_bit    (cur_bit),
    .last_bit   (last_bit)
  );

  assign busy_o = busy_q;
  assign line_o = busy_q && line_level(cur_bit, second_half);
endmodule

// File: rtl/manch_tx_chk.sv
module manch_tx_chk #(
  parameter int WORD_W     = 8,
  parameter int BIT_CYCLES = 8
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic line_o,
  input logic half_tick,
  input logic second_half,
  input logic frame_done
);
  localparam int FRAME_LEN = (WORD_W + 1) * BIT_CYCLES;

  int busy_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   busy_len <= 0;
    else if (start_i && !busy_o)  busy_len <= 0;
    else if (busy_o)              busy_len <= busy_len + 1;
  end

  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !line_o);

  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  a_r3_guard_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> !line_o);

  a_r5_mid_bit_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && !second_half) |=> (line_o != $past(line_o)));

  a_r7_hold_within_half: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !half_tick) |=> (busy_o && $stable(line_o)));

  a_r8_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_len == FRAME_LEN));

  a_r8_end_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(frame_done));

  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !frame_done) |=> busy_o);
endmodule

bind manch_tx manch_tx_chk #(.WORD_W(WORD_W), .BIT_CYCLES(BIT_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .line_o      (line_o),
  .half_tick   (half_tick),
  .second_half (second_half),
  .frame_done  (frame_done)
);

// File: tb/tb_manch_tx.sv
`timescale 1ns/1ps
module tb_manch_tx;
  localparam int WORD_W     = 8;
  localparam int BIT_CYCLES = 8;
  localparam int HALF       = BIT_CYCLES / 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [WORD_W-1:0] data_i = '0;
  logic              busy_o;
  logic              line_o;

  typedef struct {
    logic  lvl;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always #2 clk = ~clk;

  manch_tx #(.WORD_W(WORD_W), .BIT_CYCLES(BIT_CYCLES)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .data_i  (data_i),
    .busy_o  (busy_o),
    .line_o  (line_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // Expected line pattern for one frame, one entry per clock cycle.
  task automatic push_frame(input logic [WORD_W-1:0] w);
    logic [WORD_W:0] fr;
    fr = {1'b0, w};
    for (int b = WORD_W; b >= 0; b--) begin
      for (int c = 0; c < BIT_CYCLES; c++) begin
        exp_t e;
        bit   late;
        late  = (c >= HALF);
        e.lvl = late ? !fr[b] : fr[b];
        if (b == WORD_W)  e.tag = "R3 guard/R7";
        else if (fr[b])   e.tag = "R4/R5 one/R7";
        else              e.tag = "R4/R6 zero/R7";
        exp_q.push_back(e);
      end
    end
  endtask

  task automatic send(input logic [WORD_W-1:0] w);
    while (busy_o) @(negedge clk);
    start_i = 1'b1;
    data_i  = w;
    @(posedge clk);
    #0.5;
    push_frame(w);
    @(negedge clk);
    start_i = 1'b0;
    data_i  = ~w;
    check(busy_o == 1'b1, "R2 accept", busy_o, 1);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (busy_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 busy too long", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(line_o == e.lvl, e.tag, line_o, e.lvl);
        end
      end else begin
        check(line_o == 1'b0, "R1 idle low", line_o, 0);
        if (exp_q.size() != 0)
          check(1'b0, "R8 busy ended early", exp_q.size(), 0);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy_o == 1'b0, "R1 reset busy", busy_o, 0);
    check(line_o == 1'b0, "R1 reset line", line_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(busy_o == 1'b0, "R1 idle busy", busy_o, 0);

    send(8'h34);
    send(8'hFF);
    send(8'h00);
    send(8'h91);

    // R9: conflicting start in the middle of a frame
    send(8'hA5);
    repeat (3 * HALF + 1) @(negedge clk);
    start_i = 1'b1;
    data_i  = 8'h0F;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R9 busy kept", busy_o, 1);
    repeat (2) @(negedge clk);
    start_i = 1'b1;
    data_i  = 8'h5A;
    @(negedge clk);
    start_i = 1'b0;

    send(8'h80);
    send(8'h01);

    while (busy_o || exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(busy_o == 1'b0, "R8 idle after frames", busy_o, 0);
    check(line_o == 1'b0, "R1 idle after frames", line_o, 0);
    finish_run();
  end
endmodule